// File: doc/BRIEF.md
# Descriptor DMA Channel Register Bank

This block holds the software-visible control and status state for a bank of descriptor-driven DMA channels. A processor reaches it over a 32-bit, word-only register bus. Each channel owns a 128-byte window of 32 word slots. The upper address bits pick the channel and address bits [6:2] pick the slot. The block keeps a 16-bit status word for each channel. It also keeps a descriptor pointer and three condition-select words that the sequencer uses when it decides whether to interrupt, branch or wait.

Software never writes the status word directly. It writes a control word instead. The upper half of that word is a per-bit enable and the lower half is the new value, so software can set or clear single run-state bits without a read-modify-write. Interlocks then derive the ACTIVE and DEAD bits from the result. The pointer is locked while a channel runs and is always kept 16-byte aligned. The block sends the sequencer one-cycle requests to start, to flush and to fetch a descriptor.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, every channel's status, pointer and select words are zero, rdata is zero, and no request pulse is high.
- R2: On a bus access, channel = addr[11:7] and slot = addr[6:2]. A write changes only the addressed channel. Slot codes are: 0 control, 1 status, 2 pointer, 4 interrupt select, 5 branch select, 6 wait select.
- R3: A write to the control slot forms m = wdata[31:16] and v = wdata[15:0] & 16'hF0FF, then merges status = (v & m) | (old & ~m). Status bits are RUN 15, PAUSE 14, FLUSH 13, WAKE 12, DEAD 11, ACTIVE 10, BT 8, and device status [7:0].
- R4: If WAKE is set after the merge, ACTIVE is forced to 1.
- R5: If RUN is set after the merge, ACTIVE is forced to 1 and DEAD is cleared.
- R6: If PAUSE is set after the merge, ACTIVE is cleared. This takes priority over R4 and R5.
- R7: If the write moves RUN from 1 to 0, both ACTIVE and DEAD are cleared.
- R8: A pointer write is dropped when the old status has RUN or ACTIVE set. A dropped write leaves the pointer unchanged and raises no load pulse.
- R9: An accepted pointer write stores wdata with bits [3:0] forced to zero. It also raises that channel's ch_ptr_load for exactly one cycle, in the cycle after the write.
- R10: A control write whose result has ACTIVE set pulses ch_start for one cycle. A result with FLUSH set pulses ch_flush for one cycle. Both pulses appear in the cycle the new status appears.
- R11: Read data appears on rdata one cycle after rd_en and holds until the next read. The control slot, all unlisted slots and the status slot itself never change state on a write. The control slot and unlisted slots read as zero. The status slot reads {16'h0, status}.
- R12: The select slots store the full 32-bit write data and read it back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address: channel and slot |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| ch_status | output | 512 | Status word per channel, 16 bits each |
| ch_ptr | output | 1024 | Descriptor pointer per channel |
| ch_isel | output | 1024 | Interrupt condition select per channel |
| ch_bsel | output | 1024 | Branch condition select per channel |
| ch_wsel | output | 1024 | Wait condition select per channel |
| ch_ptr_load | output | 32 | Per-channel descriptor fetch pulse |
| ch_start | output | 32 | Per-channel start request pulse |
| ch_flush | output | 32 | Per-channel flush request pulse |

## Verification
Every state element sits directly on an output port, so a wrong merge or a wrong interlock shows up on ch_status in the cycle right after the offending write. It never waits for a later read. A wrongly accepted or rejected pointer write shows up the same way, on ch_ptr and on the ch_ptr_load pulse. A read-mux fault is visible on rdata one cycle after the read strobe. The bench runs a behavioural model in step with the design and compares every output on every clock, so a fault is caught at its first visible cycle.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

    // status bit positions
    localparam int ST_RUN    = 15;
    localparam int ST_PAUSE  = 14;
    localparam int ST_FLUSH  = 13;
    localparam int ST_WAKE   = 12;
    localparam int ST_DEAD   = 11;
    localparam int ST_ACTIVE = 10;
    localparam int ST_BT     = 8;

    localparam int STAT_W = 16;
    localparam int WORD_W = 32;

    // bits of the value half-word that software may drive
    localparam logic [STAT_W-1:0] WR_FILTER = 16'hF0FF;

    // slot codes within a channel window
    localparam int SLOT_CTRL = 0;
    localparam int SLOT_STAT = 1;
    localparam int SLOT_PTR  = 2;
    localparam int SLOT_ISEL = 4;
    localparam int SLOT_BSEL = 5;
    localparam int SLOT_WSEL = 6;

    localparam int PTR_ALIGN_BITS = 4;

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic [WORD_W-1:0] ptr;
        logic [WORD_W-1:0] isel;
        logic [WORD_W-1:0] bsel;
        logic [WORD_W-1:0] wsel;
        logic              start;
        logic              flush;
        logic              ptr_load;
    } slot_state_t;

endpackage

// File: rtl/dma_addr_decode.sv
module dma_addr_decode #(
    parameter int NUM_CH   = 32,
    parameter int CH_SHIFT = 7,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int IDX_W   = CH_SHIFT - 2,
    localparam int ADDR_W  = CH_SHIFT + CH_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output logic [CH_W-1:0]   ch_sel,
    output logic [IDX_W-1:0]  slot_sel,
    output logic [NUM_CH-1:0] wr_hit
);

    assign ch_sel   = addr[ADDR_W-1:CH_SHIFT];
    assign slot_sel = addr[CH_SHIFT-1:2];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
        assign wr_hit[c] = wr_en && (int'(ch_sel) == c);
    end

endmodule

// File: rtl/dma_ctrl_merge.sv
module dma_ctrl_merge
    import dma_regs_pkg::*;
(
    input  logic [STAT_W-1:0] old_status,
    input  logic [WORD_W-1:0] wdata,
    output logic [STAT_W-1:0] new_status
);

    logic [STAT_W-1:0] en_bits;
    logic [STAT_W-1:0] val_bits;
    logic [STAT_W-1:0] merged;

    always_comb begin
        en_bits  = wdata[WORD_W-1:STAT_W];
        val_bits = wdata[STAT_W-1:0] & WR_FILTER;
        merged   = (val_bits & en_bits) | (old_status & ~en_bits);

        if (merged[ST_WAKE]) begin
            merged[ST_ACTIVE] = 1'b1;
        end
        if (merged[ST_RUN]) begin
            merged[ST_ACTIVE] = 1'b1;
            merged[ST_DEAD]   = 1'b0;
        end
        if (merged[ST_PAUSE]) begin
            merged[ST_ACTIVE] = 1'b0;
        end
        if (old_status[ST_RUN] && !merged[ST_RUN]) begin
            merged[ST_ACTIVE] = 1'b0;
            merged[ST_DEAD]   = 1'b0;
        end
        new_status = merged;
    end

endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
    import dma_regs_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [IDX_W-1:0]  slot_sel,
    input  logic [WORD_W-1:0] wdata,
    output logic [STAT_W-1:0] status,
    output logic [WORD_W-1:0] ptr,
    output logic [WORD_W-1:0] isel,
    output logic [WORD_W-1:0] bsel,
    output logic [WORD_W-1:0] wsel,
    output logic              start_pulse,
    output logic              flush_pulse,
    output logic              ptr_load
);

    slot_state_t       st_d, st_q;
    logic [STAT_W-1:0] merged_status;
    logic              ptr_locked;

    dma_ctrl_merge u_merge (
        .old_status (st_q.status),
        .wdata      (wdata),
        .new_status (merged_status)
    );

    assign ptr_locked = st_q.status[ST_RUN] | st_q.status[ST_ACTIVE];

    always_comb begin
        st_d          = st_q;
        st_d.start    = 1'b0;
        st_d.flush    = 1'b0;
        st_d.ptr_load = 1'b0;
        if (wr_hit) begin
            case (int'(slot_sel))
                SLOT_CTRL: begin
                    st_d.status = merged_status;
                    st_d.start  = merged_status[ST_ACTIVE];
                    st_d.flush  = merged_status[ST_FLUSH];
                end
                SLOT_PTR: begin
                    if (!ptr_locked) begin
                        st_d.ptr      = {wdata[WORD_W-1:PTR_ALIGN_BITS], {PTR_ALIGN_BITS{1'b0}}};
                        st_d.ptr_load = 1'b1;
                    end
                end
                SLOT_ISEL: st_d.isel = wdata;
                SLOT_BSEL: st_d.bsel = wdata;
                SLOT_WSEL: st_d.wsel = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status      = st_q.status;
    assign ptr         = st_q.ptr;
    assign isel        = st_q.isel;
    assign bsel        = st_q.bsel;
    assign wsel        = st_q.wsel;
    assign start_pulse = st_q.start;
    assign flush_pulse = st_q.flush;
    assign ptr_load    = st_q.ptr_load;

endmodule

// File: rtl/dma_read_mux.sv
module dma_read_mux
    import dma_regs_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int IDX_W  = 5,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en,
    input  logic [CH_W-1:0]          ch_sel,
    input  logic [IDX_W-1:0]         slot_sel,
    input  logic [NUM_CH*STAT_W-1:0] stat_flat,
    input  logic [NUM_CH*WORD_W-1:0] ptr_flat,
    input  logic [NUM_CH*WORD_W-1:0] isel_flat,
    input  logic [NUM_CH*WORD_W-1:0] bsel_flat,
    input  logic [NUM_CH*WORD_W-1:0] wsel_flat,
    output logic [WORD_W-1:0]        rdata
);

    logic [WORD_W-1:0] rdata_d, rdata_q;
    logic [WORD_W-1:0] sel_word;
    logic              ch_ok;

    always_comb begin
        ch_ok    = int'(ch_sel) < NUM_CH;
        sel_word = '0;
        if (ch_ok) begin
            case (int'(slot_sel))
                SLOT_STAT: sel_word = {{(WORD_W-STAT_W){1'b0}}, stat_flat[int'(ch_sel)*STAT_W +: STAT_W]};
                SLOT_PTR:  sel_word = ptr_flat[int'(ch_sel)*WORD_W +: WORD_W];
                SLOT_ISEL: sel_word = isel_flat[int'(ch_sel)*WORD_W +: WORD_W];
                SLOT_BSEL: sel_word = bsel_flat[int'(ch_sel)*WORD_W +: WORD_W];
                SLOT_WSEL: sel_word = wsel_flat[int'(ch_sel)*WORD_W +: WORD_W];
                default:   sel_word = '0;
            endcase
        end
        rdata_d = rd_en ? sel_word : rdata_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regs_pkg::*;
#(
    parameter int NUM_CH   = 32,
    parameter int CH_SHIFT = 7,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int IDX_W   = CH_SHIFT - 2,
    localparam int ADDR_W  = CH_SHIFT + CH_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [WORD_W-1:0]        wdata,
    output logic [WORD_W-1:0]        rdata,
    output logic [NUM_CH*STAT_W-1:0] ch_status,
    output logic [NUM_CH*WORD_W-1:0] ch_ptr,
    output logic [NUM_CH*WORD_W-1:0] ch_isel,
    output logic [NUM_CH*WORD_W-1:0] ch_bsel,
    output logic [NUM_CH*WORD_W-1:0] ch_wsel,
    output logic [NUM_CH-1:0]        ch_ptr_load,
    output logic [NUM_CH-1:0]        ch_start,
    output logic [NUM_CH-1:0]        ch_flush
);

    logic [CH_W-1:0]   ch_sel;
    logic [IDX_W-1:0]  slot_sel;
    logic [NUM_CH-1:0] wr_hit;

    dma_addr_decode #(
        .NUM_CH   (NUM_CH),
        .CH_SHIFT (CH_SHIFT)
    ) u_decode (
        .addr     (addr),
        .wr_en    (wr_en),
        .ch_sel   (ch_sel),
        .slot_sel (slot_sel),
        .wr_hit   (wr_hit)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dma_chan_slot #(
            .IDX_W (IDX_W)
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_hit      (wr_hit[c]),
            .slot_sel    (slot_sel),
            .wdata       (wdata),
            .status      (ch_status[c*STAT_W +: STAT_W]),
            .ptr         (ch_ptr[c*WORD_W +: WORD_W]),
            .isel        (ch_isel[c*WORD_W +: WORD_W]),
            .bsel        (ch_bsel[c*WORD_W +: WORD_W]),
            .wsel        (ch_wsel[c*WORD_W +: WORD_W]),
            .start_pulse (ch_start[c]),
            .flush_pulse (ch_flush[c]),
            .ptr_load    (ch_ptr_load[c])
        );
    end

    dma_read_mux #(
        .NUM_CH (NUM_CH),
        .IDX_W  (IDX_W)
    ) u_rdmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .ch_sel    (ch_sel),
        .slot_sel  (slot_sel),
        .stat_flat (ch_status),
        .ptr_flat  (ch_ptr),
        .isel_flat (ch_isel),
        .bsel_flat (ch_bsel),
        .wsel_flat (ch_wsel),
        .rdata     (rdata)
    );

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk
    import dma_regs_pkg::*;
#(
    parameter int NUM_CH   = 32,
    parameter int CH_SHIFT = 7,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W  = CH_SHIFT + CH_W
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     rd_en,
    input logic [ADDR_W-1:0]        addr,
    input logic [WORD_W-1:0]        rdata,
    input logic [NUM_CH*STAT_W-1:0] ch_status,
    input logic [NUM_CH*WORD_W-1:0] ch_ptr,
    input logic [NUM_CH-1:0]        ch_ptr_load,
    input logic [NUM_CH-1:0]        ch_start,
    input logic [NUM_CH-1:0]        ch_flush
);

    // R11: rdata holds between reads
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R11: control slot reads as zero
    p_ctrl_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[CH_SHIFT-1:2] == '0) |=> (rdata == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R8: no pointer load while locked
        p_ptr_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_status[c*STAT_W+ST_RUN] || ch_status[c*STAT_W+ST_ACTIVE]) |=> !ch_ptr_load[c]);

        // R8: pointer only moves together with a load pulse
        p_ptr_moves_with_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_ptr_load[c] |-> $stable(ch_ptr[c*WORD_W +: WORD_W]) || $past(!rst_n));

        // R5: running and not paused means active
        p_run_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_status[c*STAT_W+ST_RUN] && !ch_status[c*STAT_W+ST_PAUSE]) |-> ch_status[c*STAT_W+ST_ACTIVE]);

        // R6: paused means not active
        p_pause_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ch_status[c*STAT_W+ST_PAUSE] |-> !ch_status[c*STAT_W+ST_ACTIVE]);

        // R10: start request only with ACTIVE status
        p_start_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ch_start[c] |-> ch_status[c*STAT_W+ST_ACTIVE]);

        // R10: flush request only with FLUSH status
        p_flush_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ch_flush[c] |-> ch_status[c*STAT_W+ST_FLUSH]);
    end

endmodule

bind dma_chan_regs dma_chan_regs_chk #(
    .NUM_CH   (NUM_CH),
    .CH_SHIFT (CH_SHIFT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .addr        (addr),
    .rdata       (rdata),
    .ch_status   (ch_status),
    .ch_ptr      (ch_ptr),
    .ch_ptr_load (ch_ptr_load),
    .ch_start    (ch_start),
    .ch_flush    (ch_flush)
);

// File: tb/dma_chan_regs_tb_top.sv
`timescale 1ns/1ps
module dma_chan_regs_tb_top;

    localparam int NCH = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [11:0]       addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [NCH*16-1:0] ch_status;
    logic [NCH*32-1:0] ch_ptr, ch_isel, ch_bsel, ch_wsel;
    logic [NCH-1:0]    ch_ptr_load, ch_start, ch_flush;

    always #2 clk = ~clk;

    dma_chan_regs dut_i (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en),
        .addr (addr), .wdata (wdata), .rdata (rdata),
        .ch_status (ch_status), .ch_ptr (ch_ptr), .ch_isel (ch_isel),
        .ch_bsel (ch_bsel), .ch_wsel (ch_wsel), .ch_ptr_load (ch_ptr_load),
        .ch_start (ch_start), .ch_flush (ch_flush)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference model
    int unsigned m_stat [NCH];
    int unsigned m_ptr  [NCH];
    int unsigned m_sel  [NCH][3];
    bit          m_start[NCH];
    bit          m_flush[NCH];
    bit          m_load [NCH];
    int unsigned m_rdata;

    function automatic int unsigned model_read(int ch, int slot);
        case (slot)
            1: return m_stat[ch];
            2: return m_ptr[ch];
            4: return m_sel[ch][0];
            5: return m_sel[ch][1];
            6: return m_sel[ch][2];
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_stat[c] = 0; m_ptr[c] = 0;
                m_sel[c][0] = 0; m_sel[c][1] = 0; m_sel[c][2] = 0;
                m_start[c] = 0; m_flush[c] = 0; m_load[c] = 0;
            end
            m_rdata = 0;
        end else begin
            int ch, slot;
            ch   = int'(addr) / 128;
            slot = (int'(addr) / 4) % 32;
            for (int c = 0; c < NCH; c++) begin
                m_start[c] = 0; m_flush[c] = 0; m_load[c] = 0;
            end
            if (rd_en) m_rdata = model_read(ch, slot);
            if (wr_en) begin
                if (slot == 0) begin
                    int unsigned en, v, s, old;
                    old = m_stat[ch];
                    en  = wdata / 65536;
                    v   = (wdata % 65536) & 32'hF0FF;
                    s   = (v & en) | (old & ~en & 32'hFFFF);
                    if (s & 32'h1000) s = s | 32'h0400;
                    if (s & 32'h8000) s = (s | 32'h0400) & ~32'h0800;
                    if (s & 32'h4000) s = s & ~32'h0400;
                    if ((old & 32'h8000) && !(s & 32'h8000)) s = s & ~32'h0C00;
                    m_stat[ch]  = s;
                    m_start[ch] = (s & 32'h0400) != 0;
                    m_flush[ch] = (s & 32'h2000) != 0;
                end else if (slot == 2) begin
                    if ((m_stat[ch] & 32'h8400) == 0) begin
                        m_ptr[ch]  = wdata & ~32'hF;
                        m_load[ch] = 1;
                    end
                end else if (slot >= 4 && slot <= 6) begin
                    m_sel[ch][slot-4] = wdata;
                end
            end
        end
    end

    // compare every output on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < NCH; c++) begin
                checks++;
                if (ch_status[c*16 +: 16] != m_stat[c][15:0]) begin
                    errors++;
                    $display("FAIL R3 ch%0d status actual %h expected %h", c, ch_status[c*16 +: 16], m_stat[c][15:0]);
                end
                if (ch_ptr[c*32 +: 32] != m_ptr[c] || ch_ptr_load[c] != m_load[c]) begin
                    errors++;
                    $display("FAIL R9 ch%0d ptr/load actual %h/%0d expected %h/%0d", c, ch_ptr[c*32 +: 32], ch_ptr_load[c], m_ptr[c], m_load[c]);
                end
                if (ch_isel[c*32 +: 32] != m_sel[c][0] || ch_bsel[c*32 +: 32] != m_sel[c][1] || ch_wsel[c*32 +: 32] != m_sel[c][2]) begin
                    errors++;
                    $display("FAIL R12 ch%0d selects actual %h %h %h expected %h %h %h", c,
                             ch_isel[c*32 +: 32], ch_bsel[c*32 +: 32], ch_wsel[c*32 +: 32], m_sel[c][0], m_sel[c][1], m_sel[c][2]);
                end
                if (ch_start[c] != m_start[c] || ch_flush[c] != m_flush[c]) begin
                    errors++;
                    $display("FAIL R10 ch%0d start/flush actual %0d/%0d expected %0d/%0d", c, ch_start[c], ch_flush[c], m_start[c], m_flush[c]);
                end
            end
            checks++;
            if (rdata != m_rdata) begin
                errors++;
                $display("FAIL R11 rdata actual %h expected %h", rdata, m_rdata);
            end
        end
    end

    function automatic logic [11:0] ad(int ch, int slot);
        return 12'(ch * 128 + slot * 4);
    endfunction

    task automatic bus_write(int ch, int slot, logic [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = ad(ch, slot); wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic bus_read(int ch, int slot, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1; addr = ad(ch, slot);
        @(negedge clk);
        rd_en = 0;
        d = rdata;
    endtask

    task automatic expect32(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        // R1: reset state
        expect32("R1 status ch0", {16'h0, ch_status[15:0]}, 32'h0);
        expect32("R1 rdata", rdata, 32'h0);
        expect32("R1 pulses", {ch_start[0], ch_flush[0], ch_ptr_load[0]}, 32'h0);
        rst_n = 1;

        // R4 + R10: WAKE sets ACTIVE, start pulse in same cycle
        @(negedge clk); wr_en = 1; addr = ad(3, 0); wdata = 32'h1000_1000;
        @(negedge clk); wr_en = 0;
        expect32("R4 wake status", {16'h0, ch_status[3*16 +: 16]}, 32'h1400);
        expect32("R10 start pulse", {31'h0, ch_start[3]}, 32'h1);
        expect32("R2 other channel", {16'h0, ch_status[0 +: 16]}, 32'h0);
        bus_read(3, 1, r);
        expect32("R11 status read", r, 32'h1400);

        // R8: pointer locked while ACTIVE
        bus_write(3, 2, 32'hAAAA_5555);
        expect32("R8 locked ptr", ch_ptr[3*32 +: 32], 32'h0);
        expect32("R8 no load", {31'h0, ch_ptr_load[3]}, 32'h0);

        // R3: full enable with zero value clears everything
        bus_write(3, 0, 32'hFFFF_0000);
        expect32("R3 clear", {16'h0, ch_status[3*16 +: 16]}, 32'h0);

        // R9: aligned pointer and one-cycle load pulse
        @(negedge clk); wr_en = 1; addr = ad(3, 2); wdata = 32'h1234_567F;
        @(negedge clk); wr_en = 0;
        expect32("R9 load pulse", {31'h0, ch_ptr_load[3]}, 32'h1);
        @(negedge clk);
        expect32("R9 pulse width", {31'h0, ch_ptr_load[3]}, 32'h0);
        bus_read(3, 2, r);
        expect32("R9 ptr aligned", r, 32'h1234_5670);

        // R5: RUN forces ACTIVE
        bus_write(3, 0, 32'h8000_8000);
        expect32("R5 run", {16'h0, ch_status[3*16 +: 16]}, 32'h8400);
        // R6: PAUSE clears ACTIVE
        bus_write(3, 0, 32'h4000_4000);
        expect32("R6 pause", {16'h0, ch_status[3*16 +: 16]}, 32'hC000);
        // R8: locked by RUN alone
        bus_write(3, 2, 32'h0000_0100);
        expect32("R8 run lock", ch_ptr[3*32 +: 32], 32'h1234_5670);
        // R7 + R3: RUN falls, device status written
        bus_write(3, 0, 32'h80FF_00A5);
        expect32("R7 run fall", {16'h0, ch_status[3*16 +: 16]}, 32'h40A5);

        // R3 + R6 + R10: filter of value half, flush pulse, PAUSE wins
        @(negedge clk); wr_en = 1; addr = ad(5, 0); wdata = 32'hFFFF_FFFF;
        @(negedge clk); wr_en = 0;
        expect32("R3 filter", {16'h0, ch_status[5*16 +: 16]}, 32'hF0FF);
        expect32("R10 flush", {30'h0, ch_flush[5], ch_start[5]}, 32'h2);
        bus_write(5, 0, 32'hFFFF_0000);
        expect32("R7 clear", {16'h0, ch_status[5*16 +: 16]}, 32'h0);

        // R11: control reads zero, status and unlisted slots ignore writes
        bus_read(3, 0, r);
        expect32("R11 ctrl read", r, 32'h0);
        bus_write(3, 1, 32'h0000_FFFF);
        bus_read(3, 1, r);
        expect32("R11 status ro", r, 32'h40A5);
        bus_write(3, 9, 32'hDEAD_BEEF);
        bus_read(3, 9, r);
        expect32("R11 unused slot", r, 32'h0);
        @(negedge clk);
        expect32("R11 rdata hold", rdata, 32'h0);

        // R12 + R2: selects on the last channel
        bus_write(31, 4, 32'h000F_0003);
        bus_write(31, 5, 32'hCAFE_0001);
        bus_write(31, 6, 32'h8001_7FFE);
        bus_read(31, 4, r); expect32("R12 isel", r, 32'h000F_0003);
        bus_read(31, 5, r); expect32("R12 bsel", r, 32'hCAFE_0001);
        bus_read(31, 6, r); expect32("R12 wsel", r, 32'h8001_7FFE);
        bus_read(30, 4, r); expect32("R2 neighbour sel", r, 32'h0);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule